// File: doc/BRIEF.md
# Dual Parallel Port Interface

A bus-attached peripheral that gives a processor two 8-bit parallel ports, A and B. Each port has a direction register, in which a 1 bit makes the pin an output, and an output register. The processor reaches the four registers through a small address window that starts at a configurable base. The two low bits of the offset pick the register. Data written to an output register is masked by that port's direction bits before it is stored. Data read back from an output register is masked again by the direction bits as they stand at the time of the read.

Every access is a single clock cycle with `sel_i` high. The block registers a response on that clock edge: the address and an 8-bit data value. Accesses outside the window leave all state alone and hand the incoming address and data straight back. Inside the window, a bus reset request clears both ports and both directions. Offsets that select no register return the last value held on an internal data latch. Pins are modelled as separate value and output-enable vectors. The interrupt output is tied inactive.

Top module: `ppi_dual_port`

## Requirements
- R1: An access acts on the block only when `addr_i` lies in [BASE_ADDR, BASE_ADDR+WINDOW), with defaults BASE_ADDR=0x1700 and WINDOW=16. Accesses outside the window change no direction or port state and do not change the data latch, even when `bus_rst_i` is high.
- R2: On an access outside the window, `addr_o` and `data_o` show the incoming `addr_i` and `wdata_i` after the clock edge that samples the access.
- R3: Offset bits [1:0] select a register: 0 = output B, 1 = output A, 2 = direction B, 3 = direction A. A write to a direction register stores the data, which then appears on the matching `*_oe_o`. A read returns that value unchanged on `data_o`.
- R4: A write to output A stores `wdata_i & dirA`. A write to output B stores `wdata_i & dirB`.
- R5: A read of output A returns the stored port A value ANDed with the current direction A; port B works the same way. This still holds after a direction register has been narrowed.
- R6: `port_a_o`/`port_b_o` carry the stored port values and `port_a_oe_o`/`port_b_oe_o` carry the direction registers. Narrowing a direction does not alter the stored port value.
- R7: An in-window access with `bus_rst_i` high clears both directions and both port values, performs no register update, and responds with `wdata_i` on `data_o`.
- R8: The data latch takes `wdata_i` on every in-window write (including writes to offsets 4..WINDOW-1) and the returned value on every read of offsets 0..3. A read of offsets 4..WINDOW-1 returns the latch and leaves it unchanged.
- R9: While `rst_ni` is low, all outputs are zero. `irq_o` is always 0.
- R10: While `sel_i` is low, no state or output changes, whatever the other bus inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| bus_rst_i | input | 1 | Bus reset request, qualified by an in-window access |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Bus data in |
| addr_o | output | 16 | Returned address |
| data_o | output | 8 | Returned data |
| port_a_o | output | 8 | Port A pin values |
| port_a_oe_o | output | 8 | Port A output enables |
| port_b_o | output | 8 | Port B pin values |
| port_b_oe_o | output | 8 | Port B output enables |
| irq_o | output | 1 | Interrupt, tied inactive |

## Verification
The properties assume that each bus input is settled and known at the rising edge where `sel_i` is sampled. They also assume that every cycle with `sel_i` high is exactly one complete access. The bench meets both assumptions by changing inputs only on falling edges and by dropping `sel_i` one falling edge after raising it. It exercises `bus_rst_i` both inside and outside the window. It also drives `bus_rst_i` and `we_i` high while `sel_i` is low, to confirm that they act only when an access is present.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int unsigned NUM_REGS = 4;

  // bit0 picks the port (1 = A), bit1 picks direction vs output
  typedef enum logic [1:0] {
    SEL_OUT_B = 2'd0,
    SEL_OUT_A = 2'd1,
    SEL_DIR_B = 2'd2,
    SEL_DIR_A = 2'd3
  } ppi_sel_e;
endpackage

// File: rtl/ppi_addr_decode.sv
module ppi_addr_decode
  import ppi_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1700,
  parameter int unsigned WINDOW    = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              impl_o,
  output ppi_sel_e          reg_sel_o
);
  localparam logic [ADDR_W:0] BASE_X = {1'b0, BASE_ADDR};
  localparam logic [ADDR_W:0] WIN_X  = (ADDR_W+1)'(WINDOW);
  localparam logic [ADDR_W:0] NREG_X = (ADDR_W+1)'(NUM_REGS);

  logic [ADDR_W:0] addr_x;
  logic [ADDR_W:0] offs;

  assign addr_x    = {1'b0, addr_i};
  assign offs      = addr_x - BASE_X;
  assign hit_o     = (addr_x >= BASE_X) && (offs < WIN_X);
  assign impl_o    = offs < NREG_X;
  assign reg_sel_o = ppi_sel_e'(offs[1:0]);
endmodule

// File: rtl/ppi_port.sv
module ppi_port #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              dir_we_i,
  input  logic              out_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] dir_o,
  output logic [DATA_W-1:0] out_o,
  output logic [DATA_W-1:0] rd_out_o
);
  logic [DATA_W-1:0] dir_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (clr_i) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (dir_we_i) dir_q <= wdata_i;
      if (out_we_i) out_q <= wdata_i & dir_q;  // stored pre-masked
    end
  end

  assign dir_o    = dir_q;
  assign out_o    = out_q;
  assign rd_out_o = out_q & dir_q;
endmodule

// File: rtl/ppi_dual_port.sv
module ppi_dual_port
  import ppi_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1700,
  parameter int unsigned WINDOW    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic              bus_rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] port_a_o,
  output logic [DATA_W-1:0] port_a_oe_o,
  output logic [DATA_W-1:0] port_b_o,
  output logic [DATA_W-1:0] port_b_oe_o,
  output logic              irq_o
);
  localparam int unsigned NUM_PORTS = 2;  // index 0 = B, 1 = A

  logic     hit, impl;
  ppi_sel_e reg_sel;

  ppi_addr_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WINDOW(WINDOW)
  ) u_dec (
    .addr_i(addr_i), .hit_o(hit), .impl_o(impl), .reg_sel_o(reg_sel)
  );

  logic acc, clr, wr;
  assign acc = sel_i & hit;
  assign clr = acc & bus_rst_i;
  assign wr  = acc & ~bus_rst_i & we_i & impl;

  logic [DATA_W-1:0] dir_w [NUM_PORTS];
  logic [DATA_W-1:0] out_w [NUM_PORTS];
  logic [DATA_W-1:0] rd_w  [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic dir_we, out_we;
    assign dir_we = wr &  reg_sel[1] & (reg_sel[0] == 1'(p));
    assign out_we = wr & ~reg_sel[1] & (reg_sel[0] == 1'(p));

    ppi_port #(.DATA_W(DATA_W)) u_port (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
      .dir_we_i(dir_we), .out_we_i(out_we), .wdata_i(wdata_i),
      .dir_o(dir_w[p]), .out_o(out_w[p]), .rd_out_o(rd_w[p])
    );
  end

  logic [DATA_W-1:0] latch_q, rd_val, latch_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    if (!impl)          rd_val = latch_q;
    else if (reg_sel[1]) rd_val = dir_w[reg_sel[0]];
    else                rd_val = rd_w[reg_sel[0]];
    latch_nxt = (bus_rst_i || we_i) ? wdata_i : rd_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (sel_i) begin
      addr_q <= addr_i;
      if (acc) begin
        latch_q <= latch_nxt;
        data_q  <= latch_nxt;
      end else begin
        data_q  <= wdata_i;  // not ours: pass through
      end
    end
  end

  assign addr_o      = addr_q;
  assign data_o      = data_q;
  assign port_a_o    = out_w[1];
  assign port_a_oe_o = dir_w[1];
  assign port_b_o    = out_w[0];
  assign port_b_oe_o = dir_w[0];
  assign irq_o       = 1'b0;
endmodule

// File: rtl/ppi_dual_port_chk.sv
module ppi_dual_port_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1700,
  parameter int unsigned WINDOW    = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic              bus_rst_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] data_o,
  input logic [DATA_W-1:0] port_a_o,
  input logic [DATA_W-1:0] port_a_oe_o,
  input logic [DATA_W-1:0] port_b_o,
  input logic [DATA_W-1:0] port_b_oe_o
);
  localparam logic [ADDR_W:0] LO = {1'b0, BASE_ADDR};
  localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(WINDOW);

  logic in_win;
  logic [ADDR_W:0] a_x, off_x;
  assign a_x    = {1'b0, addr_i};
  assign off_x  = a_x - LO;
  assign in_win = (a_x >= LO) && (a_x < HI);

  logic wr_out_a, wr_dir_a;
  assign wr_out_a = sel_i && in_win && !bus_rst_i && we_i && (off_x == 1);
  assign wr_dir_a = sel_i && in_win && !bus_rst_i && we_i && (off_x == 3);

  assert_outside_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !in_win) |=> $stable(port_a_o) && $stable(port_a_oe_o)
                        && $stable(port_b_o) && $stable(port_b_oe_o));

  assert_outside_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !in_win) |=> (addr_o == $past(addr_i)) && (data_o == $past(wdata_i)));

  assert_dir_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_a |=> port_a_oe_o == $past(wdata_i));

  assert_out_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_out_a |=> port_a_o == ($past(wdata_i) & port_a_oe_o));

  assert_bus_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && in_win && bus_rst_i) |=> (port_a_o == '0) && (port_a_oe_o == '0)
      && (port_b_o == '0) && (port_b_oe_o == '0) && (data_o == $past(wdata_i)));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(addr_o) && $stable(data_o) && $stable(port_a_o)
      && $stable(port_a_oe_o) && $stable(port_b_o) && $stable(port_b_oe_o));
endmodule

bind ppi_dual_port ppi_dual_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR), .WINDOW(WINDOW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
  .bus_rst_i(bus_rst_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .addr_o(addr_o), .data_o(data_o), .port_a_o(port_a_o),
  .port_a_oe_o(port_a_oe_o), .port_b_o(port_b_o), .port_b_oe_o(port_b_oe_o)
);

// File: tb/ppi_dual_port_tb.sv
module ppi_dual_port_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0, we_i = 1'b0, bus_rst_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [15:0] addr_o;
  logic [7:0]  data_o, port_a_o, port_a_oe_o, port_b_o, port_b_oe_o;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  ppi_dual_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .bus_rst_i(bus_rst_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .addr_o(addr_o), .data_o(data_o), .port_a_o(port_a_o),
    .port_a_oe_o(port_a_oe_o), .port_b_o(port_b_o),
    .port_b_oe_o(port_b_oe_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [15:0] a, input logic w, input logic br, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; we_i = w; bus_rst_i = br; wdata_i = d; sel_i = 1'b1;
    @(negedge clk_i);
    sel_i = 1'b0; bus_rst_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 addr_o", addr_o, 16'h0);
    chk("R9 data_o", {8'h0, data_o}, 16'h0);
    chk("R9 port_a", {port_a_oe_o, port_a_o}, 16'h0);
    chk("R9 port_b", {port_b_oe_o, port_b_o}, 16'h0);
    chk("R9 irq", {15'h0, irq_o}, 16'h0);
  endtask

  task automatic t_port_a();
    acc(16'h1703, 1'b1, 1'b0, 8'hAA);
    chk("R3 dirA oe", {8'h0, port_a_oe_o}, 16'h00AA);
    acc(16'h1701, 1'b1, 1'b0, 8'hFF);
    chk("R4 outA masked", {8'h0, port_a_o}, 16'h00AA);
    acc(16'h1701, 1'b0, 1'b0, 8'h00);
    chk("R5 read outA", {8'h0, data_o}, 16'h00AA);
    acc(16'h1703, 1'b0, 1'b0, 8'h00);
    chk("R3 read dirA", {8'h0, data_o}, 16'h00AA);
  endtask

  task automatic t_port_b();
    acc(16'h1702, 1'b1, 1'b0, 8'h55);
    acc(16'h1700, 1'b1, 1'b0, 8'hF0);
    chk("R4 outB masked", {8'h0, port_b_o}, 16'h0050);
    chk("R6 oeB", {8'h0, port_b_oe_o}, 16'h0055);
    acc(16'h1700, 0, 0, 8'h00);
    chk("R5 read outB", {8'h0, data_o}, 16'h0050);
  endtask

  task automatic t_narrow();
    acc(16'h1703, 1'b1, 1'b0, 8'h0F);
    chk("R6 stored kept", {port_a_oe_o, port_a_o}, 16'h0FAA);
    acc(16'h1701, 1'b0, 1'b0, 8'h00);
    chk("R5 read after narrow", {8'h0, data_o}, 16'h000A);
  endtask

  task automatic t_unimpl();
    acc(16'h1705, 1'b1, 1'b0, 8'h3C);
    chk("R8 write unimpl resp", {8'h0, data_o}, 16'h003C);
    chk("R8 ports untouched", {port_a_o, port_b_o}, 16'hAA50);
    acc(16'h1709, 1'b0, 1'b0, 8'h00);
    chk("R8 read latch", {8'h0, data_o}, 16'h003C);
    acc(16'h1702, 1'b0, 1'b0, 8'h00);
    acc(16'h170F, 1'b0, 1'b0, 8'hEE);
    chk("R8 latch from read, R1 top edge", {8'h0, data_o}, 16'h0055);
  endtask

  task automatic t_outside();
    acc(16'h1710, 1'b1, 1'b0, 8'h77);
    chk("R2 pass addr", addr_o, 16'h1710);
    chk("R2 pass data", {8'h0, data_o}, 16'h0077);
    chk("R1 outside write no effect", {port_a_oe_o, port_a_o}, 16'h0FAA);
    acc(16'h16FF, 1'b0, 1'b0, 8'h12);
    chk("R2 below base", {8'h0, data_o}, 16'h0012);
    acc(16'h1710, 1'b0, 1'b1, 8'h34);
    chk("R1 outside bus reset", {port_b_oe_o, port_b_o}, 16'h5550);
    acc(16'h1709, 1'b0, 1'b0, 8'h00);
    chk("R1 latch kept", {8'h0, data_o}, 16'h0055);
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b1; bus_rst_i = 1'b1; addr_i = 16'h1703; wdata_i = 8'hFF;
    repeat (3) @(negedge clk_i);
    chk("R10 idle addr", addr_o, 16'h1709);
    chk("R10 idle data", {8'h0, data_o}, 16'h0055);
    chk("R10 idle portA", {port_a_oe_o, port_a_o}, 16'h0FAA);
    bus_rst_i = 1'b0;
  endtask

  task automatic t_bus_reset();
    acc(16'h1701, 1'b1, 1'b1, 8'h99);
    chk("R7 clear A", {port_a_oe_o, port_a_o}, 16'h0000);
    chk("R7 clear B", {port_b_oe_o, port_b_o}, 16'h0000);
    chk("R7 resp", {8'h0, data_o}, 16'h0099);
    acc(16'h1703, 1'b0, 1'b0, 8'h00);
    chk("R7 dirA read zero", {8'h0, data_o}, 16'h0000);
    chk("R9 irq idle", {15'h0, irq_o}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_port_a();
    t_port_b();
    t_narrow();
    t_unimpl();
    t_outside();
    t_idle();
    t_bus_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule